// File: doc/BRIEF.md
# Length-Steered Serial Register Loader

This block is a three-wire serial write port for a frequency-synthesizer core. A host drives a serial clock, a data line and an active-low enable. While enable is low, each rising serial clock edge shifts one bit into a holding shift register, most significant bit first. The number of rising edges seen during one enable-low window alone picks which of three registers receives the data: an 8-bit configuration word, a 15-bit reference divide value or a 16-bit feedback divide value. No address bits are sent.

Loading is deferred until enable is released, so a partial or malformed frame never disturbs a live register. A write to the feedback divide value also raises a one-cycle jam-load strobe toward the divide counters. Bits leave the shift register again on a serial data-out line, delayed by 24 serial clocks and updated on the falling serial edge, so a second device on the same enable and clock can be loaded in the same long frame.

The serial pins are sampled by the block's system clock through synchronizer stages. The serial clock must therefore run well below the system clock (each serial level held for several system cycles).

Top module: `serial_cfg_loader`

## Requirements
- R1: While enable is low, each rising serial clock edge shifts the data line into the holding register; the first bit sent ends up as the most significant bit of the loaded value.
- R2: A frame of exactly 8 rising edges loads the last 8 bits sent into `cfg_q`.
- R3: A frame of exactly 15 rising edges loads the last 15 bits sent into `ref_div_q`.
- R4: A frame of exactly 24 rising edges also loads `ref_div_q`, taking only the last 15 bits sent; the first 9 are dropped.
- R5: A frame of exactly 16 rising edges loads the last 16 bits sent into `fb_div_q` and drives `jam_load` high for exactly one system clock cycle, in the cycle the new value appears.
- R6: A register changes only after enable returns high, and a frame updates its one target register and leaves the other two unchanged.
- R7: A frame with any other edge count (for example 4, 12, 17 or 32) changes no register and gives no `jam_load`; a short dummy frame of 4 or more edges after power-up brings the port to a known state so that the next valid frame loads correctly.
- R8: The edge counter stops at 31 and is cleared while enable is high, so a 40-edge frame is ignored rather than wrapping around to look like an 8-edge frame.
- R9: `ser_dout` changes only after a falling serial clock edge with enable low, and after the falling edge that follows rising edge m (m at least 24) of a frame it shows bit number m-23 of that frame.
- R10: Under reset all three registers, `ser_dout` and `jam_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data shifts on its rising edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; release commits the frame |
| ser_dout | output | 1 | Delayed serial data for a cascaded device |
| cfg_q | output | 8 | Configuration register |
| ref_div_q | output | 15 | Reference divide register |
| fb_div_q | output | 16 | Feedback divide register |
| jam_load | output | 1 | One-cycle strobe to reload both divide counters |

## Verification
The hardest case to reach is a frame long enough to push the edge counter against its ceiling, because only a frame of more than 31 edges whose length modulo 32 equals a valid length separates a saturating counter from a wrapping one. The stimulus sends a 40-edge frame after loading a known configuration word whose low byte differs from the 40-edge frame's last byte, so a wrap would visibly overwrite it. The cascade path is reached with a 32-edge frame that is itself ignored locally, while the data-out line is sampled after each falling edge from the 24th on.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 8,
  parameter int REF_W       = 15,
  parameter int FB_W        = 16,
  parameter int LONG_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_din,
  input  logic             ser_en_n,
  output logic             ser_dout,
  output logic [CFG_W-1:0] cfg_q,
  output logic [REF_W-1:0] ref_div_q,
  output logic [FB_W-1:0]  fb_div_q,
  output logic             jam_load
);
  localparam int SH_W  = LONG_W;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] N_CFG   = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] N_REF   = CNT_W'(REF_W);
  localparam logic [CNT_W-1:0] N_FB    = CNT_W'(FB_W);
  localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(LONG_W);

  logic [SYNC_STAGES-1:0] clk_sy, din_sy, en_sy;
  logic sck_d, en_d;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sy <= '0;
      din_sy <= '0;
      en_sy  <= '1;
      sck_d  <= 1'b0;
      en_d   <= 1'b1;
    end else begin
      clk_sy <= {clk_sy[SYNC_STAGES-2:0], ser_clk};
      din_sy <= {din_sy[SYNC_STAGES-2:0], ser_din};
      en_sy  <= {en_sy[SYNC_STAGES-2:0], ser_en_n};
      sck_d  <= clk_sy[SYNC_STAGES-1];
      en_d   <= en_sy[SYNC_STAGES-1];
    end
  end

  wire sck    = clk_sy[SYNC_STAGES-1];
  wire din    = din_sy[SYNC_STAGES-1];
  wire en_hi  = en_sy[SYNC_STAGES-1];
  wire s_rise = sck & ~sck_d & ~en_hi;
  wire s_fall = ~sck & sck_d & ~en_hi;
  wire commit = en_hi & ~en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      ser_dout <= 1'b0;
    end else begin
      if (en_hi)
        cnt <= '0;
      else if (s_rise && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
      if (s_rise)
        sh <= {sh[SH_W-2:0], din};
      if (s_fall)
        ser_dout <= sh[SH_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      ref_div_q <= '0;
      fb_div_q  <= '0;
      jam_load  <= 1'b0;
    end else begin
      jam_load <= 1'b0;
      if (commit) begin
        if (cnt == N_CFG)
          cfg_q <= sh[CFG_W-1:0];
        if (cnt == N_REF || cnt == N_LONG)
          ref_div_q <= sh[REF_W-1:0];
        if (cnt == N_FB) begin
          fb_div_q <= sh[FB_W-1:0];
          jam_load <= 1'b1;
        end
      end
    end
  end

  // R2/R6: configuration changes only on release after an 8-edge frame
  a_r2_cfg_needs_8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(commit && cnt == N_CFG));
  // R3/R4: reference changes only on release after a 15- or 24-edge frame
  a_r4_ref_needs_15_or_24: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_div_q) |-> $past(commit && (cnt == N_REF || cnt == N_LONG)));
  // R5: strobe comes with a 16-edge frame release
  a_r5_jam_with_fb: assert property (@(posedge clk) disable iff (!rst_n)
    jam_load |-> $past(commit && cnt == N_FB));
  a_r5_jam_single: assert property (@(posedge clk) disable iff (!rst_n)
    jam_load |=> !jam_load);
  // R6: one frame touches one register
  a_r6_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_div_q) |-> ($stable(cfg_q) && $stable(ref_div_q)));
  // R8: counter holds at its ceiling and clears while enable is high
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !en_hi) |=> cnt == CNT_MAX);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    en_hi |=> cnt == '0);
  // R9: data-out moves only after a falling serial edge
  a_r9_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> $past(s_fall));
endmodule

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NV = 10;
  // {edge count, frame bits (last sent in bit 0)}
  localparam logic [45:0] VEC [NV] = '{
    {6'd8,  40'h00_0000_00A5},
    {6'd15, 40'h00_0000_5A3C},
    {6'd16, 40'h00_0000_BEEF},
    {6'd24, 40'h00_00FF_C123},
    {6'd12, 40'h00_0000_0FFF},
    {6'd8,  40'h00_0000_003C},
    {6'd40, 40'hFF_FFFF_FF00},
    {6'd4,  40'h00_0000_0000},
    {6'd17, 40'h00_0001_2345},
    {6'd16, 40'h00_0000_0001}
  };

  logic clk = 0, rst_n = 0, ser_clk = 0, ser_din = 0, ser_en_n = 1;
  logic ser_dout, jam_load;
  logic [7:0] cfg_q;
  logic [14:0] ref_div_q;
  logic [15:0] fb_div_q;
  int checks = 0, fails = 0, jams = 0;
  logic [7:0] e_cfg = 0;
  logic [14:0] e_ref = 0;
  logic [15:0] e_fb = 0;

  serial_cfg_loader dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_en_n(ser_en_n), .ser_dout(ser_dout), .cfg_q(cfg_q), .ref_div_q(ref_div_q),
    .fb_div_q(fb_div_q), .jam_load(jam_load));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (jam_load) jams++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame;
    ser_en_n = 0;
    wait_clk(HALF);
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    wait_clk(HALF);
    ser_clk = 1;
    wait_clk(HALF);
    ser_clk = 0;
    wait_clk(HALF);
  endtask

  task automatic close_frame;
    ser_en_n = 1;
    wait_clk(8);
  endtask

  task automatic frame(input logic [39:0] bits, input int n);
    open_frame();
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
    close_frame();
  endtask

  task automatic check_all(input string req);
    chk({req, " cfg"}, 32'(cfg_q), 32'(e_cfg));
    chk({req, " ref"}, 32'(ref_div_q), 32'(e_ref));
    chk({req, " fb"}, 32'(fb_div_q), 32'(e_fb));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(3);
    // R10: reset state
    chk("R10 cfg", 32'(cfg_q), 0);
    chk("R10 ref", 32'(ref_div_q), 0);
    chk("R10 fb", 32'(fb_div_q), 0);
    chk("R10 dout", 32'(ser_dout), 0);
    chk("R10 jam", 32'(jam_load), 0);
    rst_n = 1;
    wait_clk(4);

    // R7: power-up dummy frame of 4 edges changes nothing
    frame(40'h0, 4);
    check_all("R7 init");

    for (int v = 0; v < NV; v++) begin
      int n, j0;
      logic [39:0] d;
      string tag;
      n = int'(VEC[v][45:40]);
      d = VEC[v][39:0];
      j0 = jams;
      case (n)
        8:  begin e_cfg = d[7:0];  tag = "R1 R2"; end
        15: begin e_ref = d[14:0]; tag = "R1 R3"; end
        24: begin e_ref = d[14:0]; tag = "R4"; end
        16: begin e_fb = d[15:0];  tag = "R5"; end
        40: tag = "R8";
        default: tag = "R7";
      endcase
      frame(d, n);
      check_all(tag);
      chk({tag, " jam count"}, 32'(jams - j0), (n == 16) ? 1 : 0);
    end

    // R6: nothing moves before enable is released
    open_frame();
    for (int i = 7; i >= 0; i--) send_bit(1'(8'h96 >> i));
    wait_clk(8);
    chk("R6 cfg held mid-frame", 32'(cfg_q), 32'(e_cfg));
    close_frame();
    e_cfg = 8'h96;
    check_all("R6 after release");

    // R9: cascade path, 32-edge frame ignored locally
    begin
      logic [31:0] pat;
      pat = 32'hC3A5_1E7B;
      open_frame();
      for (int m = 1; m <= 32; m++) begin
        send_bit(pat[32 - m]);
        if (m >= 24)
          chk("R9 dout", 32'(ser_dout), 32'(pat[32 - (m - 23)]));
      end
      close_frame();
      check_all("R7 32-edge");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule